// File: doc/BRIEF.md
# Ping-Pong Framebuffer Fetch Engine

This block produces the read-burst requests that pull pixel words out of memory for a display pipeline. It works from two framebuffer regions. Each region is given as a start address and an inclusive end address, where the end address is the last byte of that region. The engine steps through a region in ascending bursts. When it reaches the end of a region it moves on to the next one, and it signals the end of a frame for the region it has just completed.

In alternating mode the engine moves back and forth between region 0 and region 1. In single mode it repeats region 0. A region's two addresses are captured when fetching from that region begins. This lets the writer load new addresses into the idle region while the other region is being fetched.

Requests use a valid/ready handshake with a start address and a length in words. A new request is raised only when the downstream FIFO reports enough free space for a full burst.

Top module: `fbf_pingpong_fetch`

## Requirements
- R1: While reset is held, and after it is released with enable low, `req_valid_o`, `eof0_o` and `eof1_o` are 0.
- R2: Control bit 0 selects the region order. With 0, region 0 is fetched again after every frame. With 1, the frames go region 0, region 1, region 0, and so on.
- R3: Control bits 6:4 hold a burst code: 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16 words. Codes 5, 6 and 7 give 16 words.
- R4: A frame starts at the region's start address. It covers every word up to and including the word that holds the end-address byte. Each following request address is the previous address plus the previous length times 4 bytes.
- R5: When fewer words than a full burst remain in a region, the last request carries exactly the remaining word count. No request reaches past the end address.
- R6: A request is raised only when `fifo_space_i` is at least the full burst length. This applies to a shortened final burst too.
- R7: Once raised, a request keeps its address and length until it is accepted, even if the FIFO space or the burst code changes meanwhile.
- R8: In the cycle after the last request of region n is accepted, eofn is high and the other end-of-frame output is low. At all other times both outputs are low.
- R9: A region's start and end addresses are captured when fetching from that region begins. Writes made while the region is being fetched take effect the next time that region is used.
- R10: With enable low at a clock edge, the next cycle has no request and no end-of-frame pulse. When enable is raised again, fetching restarts at region 0.
- R11: Control bits 15:7 and 3:1 (threshold, byte order and swap settings) have no effect on the request stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Run enable; low stops the engine and rewinds it to region 0 |
| ctrl_i | input | 16 | Control word: bit 0 mode, bits 6:4 burst code, other bits unused here |
| base0_i | input | ADDR_W | Region 0 start byte address |
| ceil0_i | input | ADDR_W | Region 0 last byte address (inclusive) |
| base1_i | input | ADDR_W | Region 1 start byte address |
| ceil1_i | input | ADDR_W | Region 1 last byte address (inclusive) |
| fifo_space_i | input | SPACE_W | Free word slots in the downstream FIFO |
| req_valid_o | output | 1 | Burst request valid |
| req_ready_i | input | 1 | Burst request accepted |
| req_addr_o | output | ADDR_W | Burst start byte address |
| req_len_o | output | MAX_BURST_LOG+1 | Burst length in words |
| eof0_o | output | 1 | End-of-frame pulse for region 0 |
| eof1_o | output | 1 | End-of-frame pulse for region 1 |

## Verification
A wrong internal state appears at the ports within one request. A bad word pointer shows up as a wrong address on the very next request. A wrong region index shows up as addresses from the wrong region and as a pulse on the wrong end-of-frame output, one cycle after that frame's final acceptance. A bad remaining-word count shows up as a final burst that is too long or too short, and as an end-of-frame pulse that comes too early or too late. Any of these is caught by comparing every request against an address walk computed from the region bounds.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
   localparam int CODE_W   = 3;
   localparam int CTRL_W   = 16;
   localparam int MODE_BIT = 0;
   localparam int CODE_LSB = 4;

   typedef enum logic {
      BUF_A = 1'b0,
      BUF_B = 1'b1
   } buf_idx_e;
endpackage

// File: rtl/fbf_len_calc.sv
module fbf_len_calc #(
   parameter int ADDR_W  = 32,
   parameter int MAX_LOG = 4,
   parameter int LEN_W   = MAX_LOG + 1
) (
   input  logic                          clk_i,
   input  logic                          rst_n_i,
   input  logic [fbf_pkg::CODE_W-1:0]    code_i,
   input  logic [ADDR_W-1:0]             rem_i,
   output logic [LEN_W-1:0]              full_len_o,
   output logic [LEN_W-1:0]              fit_len_o
);
   localparam int NCODES = 1 << fbf_pkg::CODE_W;

   generate
      if (MAX_LOG < 0 || MAX_LOG >= NCODES) begin : g_bad_log
         $error("fbf_len_calc: MAX_LOG out of range");
      end
      if (LEN_W < MAX_LOG + 1) begin : g_bad_len
         $error("fbf_len_calc: LEN_W too narrow");
      end
   endgenerate

   logic [LEN_W-1:0] len_tbl [NCODES];

   for (genvar g = 0; g < NCODES; g++) begin : g_tbl
      if (g <= MAX_LOG) begin : g_pow
         assign len_tbl[g] = LEN_W'(1) << g;
      end else begin : g_clamp
         assign len_tbl[g] = LEN_W'(1) << MAX_LOG;
      end
   end

   assign full_len_o = len_tbl[code_i];
   assign fit_len_o  = (rem_i < ADDR_W'(full_len_o)) ? rem_i[LEN_W-1:0] : full_len_o;

   // R3: burst length is a power of two and the fitted length never exceeds it
   a_r3_len_shape: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($countones(full_len_o) == 1) && (fit_len_o <= full_len_o));
endmodule

// File: rtl/fbf_buf_pick.sv
module fbf_buf_pick #(
   parameter int ADDR_W = 32
) (
   input  fbf_pkg::buf_idx_e    sel_i,
   input  logic [ADDR_W-1:0]    base0_i,
   input  logic [ADDR_W-1:0]    ceil0_i,
   input  logic [ADDR_W-1:0]    base1_i,
   input  logic [ADDR_W-1:0]    ceil1_i,
   output logic [ADDR_W-1:0]    base_o,
   output logic [ADDR_W-1:0]    ceil_o
);
   always_comb begin
      if (sel_i == fbf_pkg::BUF_B) begin
         base_o = base1_i;
         ceil_o = ceil1_i;
      end else begin
         base_o = base0_i;
         ceil_o = ceil0_i;
      end
   end
endmodule

// File: rtl/fbf_pingpong_fetch.sv
module fbf_pingpong_fetch #(
   parameter int ADDR_W        = 32,
   parameter int WORD_BYTES    = 4,
   parameter int SPACE_W       = 8,
   parameter int MAX_BURST_LOG = 4,
   localparam int LEN_W        = MAX_BURST_LOG + 1
) (
   input  logic                        clk_i,
   input  logic                        rst_n_i,
   input  logic                        enable_i,
   input  logic [fbf_pkg::CTRL_W-1:0]  ctrl_i,
   input  logic [ADDR_W-1:0]           base0_i,
   input  logic [ADDR_W-1:0]           ceil0_i,
   input  logic [ADDR_W-1:0]           base1_i,
   input  logic [ADDR_W-1:0]           ceil1_i,
   input  logic [SPACE_W-1:0]          fifo_space_i,
   output logic                        req_valid_o,
   input  logic                        req_ready_i,
   output logic [ADDR_W-1:0]           req_addr_o,
   output logic [LEN_W-1:0]            req_len_o,
   output logic                        eof0_o,
   output logic                        eof1_o
);
   import fbf_pkg::*;

   localparam int WB_LOG = $clog2(WORD_BYTES);

   generate
      if (WORD_BYTES < 1 || (1 << WB_LOG) != WORD_BYTES) begin : g_bad_wb
         $error("fbf_pingpong_fetch: WORD_BYTES must be a power of two");
      end
      if (SPACE_W < LEN_W) begin : g_bad_space
         $error("fbf_pingpong_fetch: SPACE_W narrower than burst length");
      end
      if (ADDR_W <= WB_LOG + LEN_W) begin : g_bad_addr
         $error("fbf_pingpong_fetch: ADDR_W too small");
      end
   endgenerate

   // control fields consumed here; the rest belong to the unpacking stage
   logic                dual_mode;
   logic [CODE_W-1:0]   burst_code;
   logic                ctrl_unused;
   assign dual_mode   = ctrl_i[MODE_BIT];
   assign burst_code  = ctrl_i[CODE_LSB +: CODE_W];
   assign ctrl_unused = ^{ctrl_i[CTRL_W-1:CODE_LSB+CODE_W], ctrl_i[CODE_LSB-1:MODE_BIT+1]};

   logic                run_q, pend_q, eof0_q, eof1_q;
   buf_idx_e            cur_q, nxt_sel;
   logic [ADDR_W-1:0]   ptr_q, ceil_q;
   logic [LEN_W-1:0]    held_q;

   logic [ADDR_W-1:0]   pick_base, pick_ceil, rem_words;
   logic [LEN_W-1:0]    full_len, fit_len;
   logic                hs, last_burst;

   // region that the next frame uses: region 0 on start-up or in single mode
   always_comb begin
      if (run_q && dual_mode) nxt_sel = (cur_q == BUF_A) ? BUF_B : BUF_A;
      else                    nxt_sel = BUF_A;
   end

   fbf_buf_pick #(.ADDR_W(ADDR_W)) u_pick (
      .sel_i   (nxt_sel),
      .base0_i (base0_i),
      .ceil0_i (ceil0_i),
      .base1_i (base1_i),
      .ceil1_i (ceil1_i),
      .base_o  (pick_base),
      .ceil_o  (pick_ceil)
   );

   assign rem_words = ((ceil_q - ptr_q) >> WB_LOG) + ADDR_W'(1);

   fbf_len_calc #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_BURST_LOG), .LEN_W(LEN_W)) u_len (
      .clk_i      (clk_i),
      .rst_n_i    (rst_n_i),
      .code_i     (burst_code),
      .rem_i      (rem_words),
      .full_len_o (full_len),
      .fit_len_o  (fit_len)
   );

   assign req_len_o   = pend_q ? held_q : fit_len;
   assign req_valid_o = run_q && (pend_q || (fifo_space_i >= SPACE_W'(full_len)));
   assign req_addr_o  = ptr_q;
   assign hs          = req_valid_o && req_ready_i;
   assign last_burst  = (ADDR_W'(req_len_o) == rem_words);
   assign eof0_o      = eof0_q;
   assign eof1_o      = eof1_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
         cur_q  <= BUF_A;
         ptr_q  <= '0;
         ceil_q <= '0;
         held_q <= '0;
         eof0_q <= 1'b0;
         eof1_q <= 1'b0;
      end else begin
         eof0_q <= enable_i && hs && last_burst && (cur_q == BUF_A);
         eof1_q <= enable_i && hs && last_burst && (cur_q == BUF_B);
         if (!enable_i) begin
            run_q  <= 1'b0;
            pend_q <= 1'b0;
            cur_q  <= BUF_A;
         end else if (!run_q) begin
            run_q  <= 1'b1;
            pend_q <= 1'b0;
            cur_q  <= BUF_A;
            ptr_q  <= pick_base;
            ceil_q <= pick_ceil;
         end else if (hs) begin
            pend_q <= 1'b0;
            if (last_burst) begin
               cur_q  <= nxt_sel;
               ptr_q  <= pick_base;
               ceil_q <= pick_ceil;
            end else begin
               ptr_q <= ptr_q + (ADDR_W'(req_len_o) << WB_LOG);
            end
         end else if (req_valid_o) begin
            pend_q <= 1'b1;
            held_q <= req_len_o;
         end
      end
   end

   // R5: a request never runs past the captured end address
   a_r5_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      req_valid_o |-> ({1'b0, req_addr_o} + ({1'b0, ADDR_W'(req_len_o)} << WB_LOG) - 1'b1)
                      <= {1'b0, ceil_q});

   // R6: a fresh request only appears with room for a whole burst
   a_r6_space: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(req_valid_o) |-> (fifo_space_i >= SPACE_W'(full_len)));

   // R7: an unaccepted request stays put
   a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (req_valid_o && !req_ready_i && enable_i) |=>
         (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)));

   // R8: end-of-frame pulses follow an acceptance and never coincide
   a_r8_eof_src: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (eof0_o || eof1_o) |-> $past(req_valid_o && req_ready_i));
   a_r8_eof_excl: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $onehot0({eof0_o, eof1_o}));

   // R10: disabling silences the engine on the next cycle
   a_r10_off: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !enable_i |=> (!req_valid_o && !eof0_o && !eof1_o));
endmodule

// File: tb/fbf_pingpong_fetch_tb.sv
module fbf_pingpong_fetch_tb_top;
   localparam int AW = 32;
   localparam int LW = 5;

   logic          clk = 1'b0;
   logic          rst_n, enable, ready, valid, eof0, eof1;
   logic [15:0]   ctrl;
   logic [AW-1:0] b0, c0, b1, c1, addr;
   logic [7:0]    space;
   logic [LW-1:0] len;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   fbf_pingpong_fetch dut_i (
      .clk_i        (clk),
      .rst_n_i      (rst_n),
      .enable_i     (enable),
      .ctrl_i       (ctrl),
      .base0_i      (b0),
      .ceil0_i      (c0),
      .base1_i      (b1),
      .ceil1_i      (c1),
      .fifo_space_i (space),
      .req_valid_o  (valid),
      .req_ready_i  (ready),
      .req_addr_o   (addr),
      .req_len_o    (len),
      .eof0_o       (eof0),
      .eof1_o       (eof1)
   );

   typedef struct packed {
      logic [31:0] base0;
      logic [31:0] ceil0;
      logic [31:0] base1;
      logic [31:0] ceil1;
      logic [15:0] ctrl;
      logic [7:0]  n0;
      logic [7:0]  n1;
   } vec_t;

   localparam vec_t TBL [5] = '{
      '{32'h1000, 32'h103F, 32'h2000, 32'h201F, 16'h0021, 8'd4, 8'd2},
      '{32'h0100, 32'h012B, 32'h0900, 32'h090F, 16'h0030, 8'd2, 8'd0},
      '{32'h0040, 32'h004B, 32'h0080, 32'h0083, 16'h0001, 8'd3, 8'd1},
      '{32'h0000, 32'h00FF, 32'h0400, 32'h043B, 16'h0041, 8'd4, 8'd1},
      '{32'h0800, 32'h0887, 32'h0C00, 32'h0C0F, 16'hFF7A, 8'd3, 8'd0}
   };

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; enable = 1'b0; ready = 1'b1; ctrl = 16'h0;
      b0 = '0; c0 = '0; b1 = '0; c1 = '0; space = 8'd200;
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset
      chk(!valid && !eof0 && !eof1, "R1", {valid, eof0, eof1}, 0);
      rst_n = 1'b1;
      step();
      chk(!valid && !eof0 && !eof1, "R1", {valid, eof0, eof1}, 0);

      // table walk: three frames per vector, every request compared
      for (int v = 0; v < 5; v++) begin
         vec_t cfg;
         bit   dual, cur, e0, e1;
         int   blen, code;
         cfg = TBL[v];
         b0 = cfg.base0; c0 = cfg.ceil0; b1 = cfg.base1; c1 = cfg.ceil1; ctrl = cfg.ctrl;
         enable = 1'b0;
         step(); step();
         enable = 1'b1;
         step();
         dual = cfg.ctrl[0];
         code = int'(cfg.ctrl[6:4]);
         blen = 1 << ((code > 4) ? 4 : code);
         cur = 1'b0; e0 = 1'b0; e1 = 1'b0;
         for (int f = 0; f < 3; f++) begin
            longint ptr, rem, lim;
            int cnt, l;
            ptr = cur ? cfg.base1 : cfg.base0;
            lim = cur ? cfg.ceil1 : cfg.ceil0;
            rem = ((lim - ptr) >> 2) + 1;
            cnt = 0;
            while (rem > 0) begin
               l = (rem < blen) ? int'(rem) : blen;
               chk(valid == 1'b1, "R6", valid, 1);
               chk(addr == AW'(ptr), (v == 4) ? "R11" : "R4", addr, ptr);
               chk(len == LW'(l), (rem < blen) ? "R5" : "R3", len, l);
               chk(eof0 == e0 && eof1 == e1, "R8", {eof1, eof0}, {e1, e0});
               e0 = (l == rem) && !cur;
               e1 = (l == rem) && cur;
               ptr += l * 4;
               rem -= l;
               cnt++;
               step();
            end
            chk(cnt == int'(cur ? cfg.n1 : cfg.n0), "R2", cnt, cur ? cfg.n1 : cfg.n0);
            cur = dual ? !cur : 1'b0;
         end
         chk(eof0 == e0 && eof1 == e1, "R8", {eof1, eof0}, {e1, e0});
         enable = 1'b0;
      end

      // R6 / R5: 3-word region, 4-word bursts, limited FIFO space
      step();
      b0 = 32'h3000; c0 = 32'h300B; ctrl = 16'h0020; space = 8'd3;
      enable = 1'b1;
      step(); step(); step();
      chk(valid == 1'b0, "R6", valid, 0);
      space = 8'd4;
      ready = 1'b0;
      step();
      chk(valid == 1'b1, "R6", valid, 1);
      chk(len == 5'd3, "R5", len, 3);
      chk(addr == 32'h3000, "R4", addr, 32'h3000);
      // R7: request holds through space drop and code change
      space = 8'd0; ctrl = 16'h0000;
      step(); step();
      chk(valid == 1'b1 && len == 5'd3 && addr == 32'h3000, "R7", {valid, len, addr}, {1'b1, 5'd3, 32'h3000});
      ctrl = 16'h0020; space = 8'd4; ready = 1'b1;
      step();
      chk(eof0 == 1'b1 && eof1 == 1'b0, "R8", {eof1, eof0}, 1);
      chk(addr == 32'h3000, "R2", addr, 32'h3000);

      // R9: capture of region addresses at frame start
      enable = 1'b0; space = 8'd200;
      step();
      b0 = 32'h4000; c0 = 32'h401F; b1 = 32'h5000; c1 = 32'h500F; ctrl = 16'h0021;
      enable = 1'b1;
      step();
      chk(addr == 32'h4000, "R9", addr, 32'h4000);
      b0 = 32'h7000; c0 = 32'h700F; b1 = 32'h6000; c1 = 32'h6007;
      step();
      chk(addr == 32'h4010, "R9", addr, 32'h4010);
      step();
      chk(addr == 32'h6000 && len == 5'd2, "R9", {addr, len}, {32'h6000, 5'd2});
      chk(eof0 == 1'b1, "R8", eof0, 1);
      step();
      chk(addr == 32'h7000 && len == 5'd4, "R9", {addr, len}, {32'h7000, 5'd4});
      chk(eof1 == 1'b1 && eof0 == 1'b0, "R8", {eof1, eof0}, 2);
      step();
      chk(addr == 32'h6000, "R2", addr, 32'h6000);

      // R10: disable while in region 1, restart lands in region 0
      enable = 1'b0;
      step();
      chk(!valid && !eof0 && !eof1, "R10", {valid, eof0, eof1}, 0);
      enable = 1'b1;
      step();
      chk(valid == 1'b1 && addr == 32'h7000, "R10", addr, 32'h7000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule